// File: doc/BRIEF.md
# In-Order Load/Store Queue

This block is a circular buffer of memory operations sitting between the dispatch stage of an out-of-order core and the data memory port. Each accepted operation carries a reorder-buffer tag, an access code, an immediate and up to two source operands. The first operand forms the address and the second carries store data. An operand is captured in one of two ways. In the cycle after the operation is written, a register-file lookup and a reorder-buffer lookup are presented. Later, the operand can be picked up by listening to result broadcasts from the ALU and from memory. Operations leave strictly in arrival order: only the oldest entry may issue a memory request, and only once every operand it uses holds a value.

The issue side is a valid/ready stream. `iss_ready` is high whenever at least one slot is free, and an operation is taken on a clock edge where `iss_valid` and `iss_ready` are both high. The request side is a valid/ready stream with a single output register. A request stays on the pins, unchanged, until `req_ready` is seen high. While it waits, the queue head does not advance. The number of free slots is exported every cycle. A flush input discards every entry and any pending request.

Top module: `load_store_queue`

## Requirements
- R1: After reset, and on the edge after `flush` is high, the queue is empty: `free_cnt` equals the depth (32), `iss_ready` is 1, `req_valid` is 0 and `req_type` is 0.
- R2: An operation is accepted on an edge where `iss_valid` and `iss_ready` are both 1. `iss_ready` is 1 exactly when `free_cnt` is non-zero. An issue attempt while `free_cnt` is 0 changes nothing.
- R3: Only the oldest entry may execute. A younger entry whose operands are all ready waits behind an older entry that is still missing an operand.
- R4: A request presents `req_addr` equal to operand A plus the immediate (modulo 2^32), `req_data` equal to operand B, `req_type` equal to the accepted `iss_op`, and `req_rob` equal to `iss_rob`. Whenever `req_valid` is 0, `req_type` is 0.
- R5: In the cycle after acceptance, each used operand resolves with this priority. First, if `lk_x_nodep` is 1, it takes the register value. Next, if `lk_x_rob_hit` is 1, it takes the reorder-buffer value. Next, it takes an ALU broadcast whose index equals `lk_x_tag`. Next, it takes a memory broadcast whose index equals `lk_x_tag`. Otherwise it waits on `lk_x_tag`.
- R6: A waiting operand of any resolved entry captures a broadcast whose index equals its tag. A broadcast counts only when its status field is 2'b10. When the ALU and memory broadcasts both match, the ALU value is taken.
- R7: While `req_valid` is 1 and `req_ready` is 0, the request fields stay stable and no entry leaves the queue.
- R8: `free_cnt` decreases by one for each accepted operation and increases by one for each entry that executes. It is unchanged when both happen on the same edge.
- R9: `flush` wins over a simultaneous issue. The operation offered on the flush edge is dropped.
- R10: An operation accepted on edge E is resolved on edge E+1. It can be executed on edge E+2 at the earliest, so `req_valid` cannot show it before then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard all entries and the pending request |
| iss_valid | input | 1 | Issue stream valid |
| iss_ready | output | 1 | Issue stream ready (a slot is free) |
| iss_rob | input | 5 | Reorder-buffer tag of the operation |
| iss_op | input | 3 | Access code passed to memory (non-zero for real accesses) |
| iss_imm | input | 32 | Address offset |
| iss_use_a | input | 1 | Operation uses operand A (address base) |
| iss_use_b | input | 1 | Operation uses operand B (store data) |
| lk_a_nodep | input | 1 | Register file reports operand A has no pending producer |
| lk_a_rf_val | input | 32 | Register-file value for operand A |
| lk_a_tag | input | 5 | Producer tag for operand A |
| lk_a_rob_hit | input | 1 | Reorder buffer already holds operand A |
| lk_a_rob_val | input | 32 | Reorder-buffer value for operand A |
| lk_b_nodep | input | 1 | Register file reports operand B has no pending producer |
| lk_b_rf_val | input | 32 | Register-file value for operand B |
| lk_b_tag | input | 5 | Producer tag for operand B |
| lk_b_rob_hit | input | 1 | Reorder buffer already holds operand B |
| lk_b_rob_val | input | 32 | Reorder-buffer value for operand B |
| alu_status | input | 2 | ALU broadcast status, 2'b10 means a result is present |
| alu_idx | input | 5 | Tag of the ALU result |
| alu_val | input | 32 | ALU result value |
| mem_status | input | 2 | Memory broadcast status, 2'b10 means a result is present |
| mem_idx | input | 5 | Tag of the memory result |
| mem_val | input | 32 | Memory result value |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_type | output | 3 | Access code of the request, 0 when idle |
| req_addr | output | 32 | Request address |
| req_data | output | 32 | Store data |
| req_rob | output | 5 | Reorder-buffer tag of the request |
| free_cnt | output | 6 | Number of free slots |

## Verification
The embedded assertions watch the free-slot arithmetic on every edge: one down per accept, one up per execute, and back to the depth after a flush. They also check that a stalled request holds still, that `req_type` is zero whenever no request is valid, and that an entry is never executed in the cycle it is still being resolved. Operand forwarding priority, broadcast snooping with the status filter, and strict arrival order only show up as address and data values at the request port. These are covered by the bench's directed scenarios and by its reference model, which is compared against the design on every clock under long random traffic with stalls and flushes.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  localparam int unsigned LSQ_DATA_W = 32;
  localparam int unsigned LSQ_TAG_W  = 5;
  localparam int unsigned LSQ_OP_W   = 3;
  localparam logic [1:0]  BC_DONE    = 2'b10;

  typedef struct packed {
    logic                  used;
    logic                  rdy;
    logic [LSQ_TAG_W-1:0]  tag;
    logic [LSQ_DATA_W-1:0] val;
  } lsq_opnd_t;

  typedef struct packed {
    logic                  vld;
    logic                  res;
    logic [LSQ_TAG_W-1:0]  rob;
    logic [LSQ_OP_W-1:0]   op;
    logic [LSQ_DATA_W-1:0] imm;
    lsq_opnd_t             a;
    lsq_opnd_t             b;
  } lsq_entry_t;

  typedef struct packed {
    logic                  vld;
    logic [LSQ_TAG_W-1:0]  idx;
    logic [LSQ_DATA_W-1:0] val;
  } lsq_bcast_t;

  typedef struct packed {
    logic                  nodep;
    logic [LSQ_DATA_W-1:0] rf_val;
    logic [LSQ_TAG_W-1:0]  tag;
    logic                  rob_hit;
    logic [LSQ_DATA_W-1:0] rob_val;
  } lsq_lookup_t;
endpackage

// File: rtl/lsq_opnd_resolve.sv
module lsq_opnd_resolve
  import lsq_pkg::*;
(
  input  lsq_opnd_t   cur,
  input  logic        fresh,
  input  lsq_lookup_t lk,
  input  lsq_bcast_t  bc_alu,
  input  lsq_bcast_t  bc_mem,
  output lsq_opnd_t   nxt
);
  always_comb begin
    nxt = cur;
    if (cur.used) begin
      if (fresh) begin
        // first look: register file, then reorder buffer, then live broadcasts
        if (lk.nodep) begin
          nxt.rdy = 1'b1;
          nxt.val = lk.rf_val;
        end else if (lk.rob_hit) begin
          nxt.rdy = 1'b1;
          nxt.val = lk.rob_val;
        end else if (bc_alu.vld && bc_alu.idx == lk.tag) begin
          nxt.rdy = 1'b1;
          nxt.val = bc_alu.val;
          nxt.tag = lk.tag;
        end else if (bc_mem.vld && bc_mem.idx == lk.tag) begin
          nxt.rdy = 1'b1;
          nxt.val = bc_mem.val;
          nxt.tag = lk.tag;
        end else begin
          nxt.rdy = 1'b0;
          nxt.tag = lk.tag;
        end
      end else if (!cur.rdy) begin
        // steady state: snoop broadcasts on the recorded tag
        if (bc_alu.vld && bc_alu.idx == cur.tag) begin
          nxt.rdy = 1'b1;
          nxt.val = bc_alu.val;
        end else if (bc_mem.vld && bc_mem.idx == cur.tag) begin
          nxt.rdy = 1'b1;
          nxt.val = bc_mem.val;
        end
      end
    end
  end
endmodule

// File: rtl/lsq_ring_ptrs.sv
module lsq_ring_ptrs #(
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] free_cnt
);
  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head     <= '0;
      tail     <= '0;
      free_cnt <= CNT_W'(DEPTH);
    end else if (flush) begin
      head     <= '0;
      tail     <= '0;
      free_cnt <= CNT_W'(DEPTH);
    end else begin
      if (push) tail <= adv(tail);
      if (pop)  head <= adv(head);
      free_cnt <= free_cnt - CNT_W'(push) + CNT_W'(pop);
    end
  end

  assert_free_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CNT_W'(DEPTH));

  assert_accept_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |=> free_cnt == $past(free_cnt) - CNT_W'(1));

  assert_exec_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush) |=> free_cnt == $past(free_cnt) + CNT_W'(1));

  assert_flush_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (free_cnt == CNT_W'(DEPTH)) && (head == tail));
endmodule

// File: rtl/lsq_req_stage.sv
module lsq_req_stage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 5,
  parameter int unsigned OP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [OP_W-1:0]   in_type,
  input  logic [DATA_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TAG_W-1:0]  in_rob,
  output logic              can_load,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [OP_W-1:0]   req_type,
  output logic [DATA_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [TAG_W-1:0]  req_rob
);
  assign can_load = !req_valid || req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_type  <= '0;
      req_addr  <= '0;
      req_data  <= '0;
      req_rob   <= '0;
    end else if (flush) begin
      req_valid <= 1'b0;
      req_type  <= '0;
    end else if (load) begin
      req_valid <= 1'b1;
      req_type  <= in_type;
      req_addr  <= in_addr;
      req_data  <= in_data;
      req_rob   <= in_rob;
    end else if (req_ready) begin
      req_valid <= 1'b0;
      req_type  <= '0;
    end
  end

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !flush) |=>
      (req_valid && $stable(req_type) && $stable(req_addr) && $stable(req_data) && $stable(req_rob)));
endmodule

// File: rtl/load_store_queue.sv
module load_store_queue
  import lsq_pkg::*;
#(
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  iss_valid,
  output logic                  iss_ready,
  input  logic [LSQ_TAG_W-1:0]  iss_rob,
  input  logic [LSQ_OP_W-1:0]   iss_op,
  input  logic [LSQ_DATA_W-1:0] iss_imm,
  input  logic                  iss_use_a,
  input  logic                  iss_use_b,
  input  logic                  lk_a_nodep,
  input  logic [LSQ_DATA_W-1:0] lk_a_rf_val,
  input  logic [LSQ_TAG_W-1:0]  lk_a_tag,
  input  logic                  lk_a_rob_hit,
  input  logic [LSQ_DATA_W-1:0] lk_a_rob_val,
  input  logic                  lk_b_nodep,
  input  logic [LSQ_DATA_W-1:0] lk_b_rf_val,
  input  logic [LSQ_TAG_W-1:0]  lk_b_tag,
  input  logic                  lk_b_rob_hit,
  input  logic [LSQ_DATA_W-1:0] lk_b_rob_val,
  input  logic [1:0]            alu_status,
  input  logic [LSQ_TAG_W-1:0]  alu_idx,
  input  logic [LSQ_DATA_W-1:0] alu_val,
  input  logic [1:0]            mem_status,
  input  logic [LSQ_TAG_W-1:0]  mem_idx,
  input  logic [LSQ_DATA_W-1:0] mem_val,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [LSQ_OP_W-1:0]   req_type,
  output logic [LSQ_DATA_W-1:0] req_addr,
  output logic [LSQ_DATA_W-1:0] req_data,
  output logic [LSQ_TAG_W-1:0]  req_rob,
  output logic [CNT_W-1:0]      free_cnt
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  lsq_entry_t       ent_q [DEPTH];
  lsq_entry_t       ent_d [DEPTH];
  lsq_entry_t       hd;
  logic [PTR_W-1:0] head, tail;
  logic             pend_q;
  logic [PTR_W-1:0] pend_idx_q;
  logic             acc, exec, head_go, stage_free;
  lsq_lookup_t      lk_a, lk_b;
  lsq_bcast_t       bc_alu, bc_mem;

  always_comb begin
    lk_a   = '{nodep: lk_a_nodep, rf_val: lk_a_rf_val, tag: lk_a_tag,
               rob_hit: lk_a_rob_hit, rob_val: lk_a_rob_val};
    lk_b   = '{nodep: lk_b_nodep, rf_val: lk_b_rf_val, tag: lk_b_tag,
               rob_hit: lk_b_rob_hit, rob_val: lk_b_rob_val};
    bc_alu = '{vld: (alu_status == BC_DONE), idx: alu_idx, val: alu_val};
    bc_mem = '{vld: (mem_status == BC_DONE), idx: mem_idx, val: mem_val};
  end

  assign iss_ready = (free_cnt != '0);
  assign acc       = iss_valid && iss_ready && !flush;
  assign hd        = ent_q[head];
  assign head_go   = hd.vld && hd.res && (!hd.a.used || hd.a.rdy) && (!hd.b.used || hd.b.rdy);
  assign exec      = head_go && stage_free && !flush;

  lsq_ring_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(acc), .pop(exec),
    .head(head), .tail(tail), .free_cnt(free_cnt)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic       fresh;
    lsq_opnd_t  nxt_a, nxt_b;
    lsq_entry_t nxt;

    assign fresh = pend_q && (pend_idx_q == PTR_W'(i));

    lsq_opnd_resolve u_res_a (
      .cur(ent_q[i].a), .fresh(fresh), .lk(lk_a), .bc_alu(bc_alu), .bc_mem(bc_mem), .nxt(nxt_a)
    );
    lsq_opnd_resolve u_res_b (
      .cur(ent_q[i].b), .fresh(fresh), .lk(lk_b), .bc_alu(bc_alu), .bc_mem(bc_mem), .nxt(nxt_b)
    );

    always_comb begin
      nxt = ent_q[i];
      if (ent_q[i].vld) begin
        nxt.a = nxt_a;
        nxt.b = nxt_b;
        if (fresh) nxt.res = 1'b1;
        if (exec && head == PTR_W'(i)) nxt.vld = 1'b0;
      end
      if (acc && tail == PTR_W'(i)) begin
        nxt     = '0;
        nxt.vld = 1'b1;
        nxt.rob = iss_rob;
        nxt.op  = iss_op;
        nxt.imm = iss_imm;
        nxt.a.used = iss_use_a;
        nxt.b.used = iss_use_b;
      end
    end

    assign ent_d[i] = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) ent_q[k] <= '0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else if (flush) begin
      for (int k = 0; k < DEPTH; k++) ent_q[k] <= '0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) ent_q[k] <= ent_d[k];
      pend_q     <= acc;
      pend_idx_q <= tail;
    end
  end

  lsq_req_stage #(.DATA_W(LSQ_DATA_W), .TAG_W(LSQ_TAG_W), .OP_W(LSQ_OP_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .flush(flush), .load(exec),
    .in_type(hd.op), .in_addr(hd.a.val + hd.imm), .in_data(hd.b.val), .in_rob(hd.rob),
    .can_load(stage_free),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_addr(req_addr), .req_data(req_data), .req_rob(req_rob)
  );

  assert_idle_type_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (req_type == '0));

  assert_no_exec_while_resolving_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !(exec && head == pend_idx_q));

  assert_exec_loads_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> req_valid);

  assert_full_blocks_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == '0 && !exec && !flush) |=> (free_cnt == '0));
endmodule

// File: tb/load_store_queue_bench.sv
`timescale 1ns/1ps
module load_store_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        iss_valid = 1'b0;
  logic        iss_ready;
  logic [4:0]  iss_rob = '0;
  logic [2:0]  iss_op = '0;
  logic [31:0] iss_imm = '0;
  logic        iss_use_a = 1'b0, iss_use_b = 1'b0;
  logic        lk_a_nodep = 1'b0, lk_a_rob_hit = 1'b0;
  logic [31:0] lk_a_rf_val = '0, lk_a_rob_val = '0;
  logic [4:0]  lk_a_tag = '0;
  logic        lk_b_nodep = 1'b0, lk_b_rob_hit = 1'b0;
  logic [31:0] lk_b_rf_val = '0, lk_b_rob_val = '0;
  logic [4:0]  lk_b_tag = '0;
  logic [1:0]  alu_status = '0, mem_status = '0;
  logic [4:0]  alu_idx = '0, mem_idx = '0;
  logic [31:0] alu_val = '0, mem_val = '0;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [2:0]  req_type;
  logic [31:0] req_addr, req_data;
  logic [4:0]  req_rob;
  logic [5:0]  free_cnt;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  load_store_queue u_load_store_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_rob(iss_rob), .iss_op(iss_op),
    .iss_imm(iss_imm), .iss_use_a(iss_use_a), .iss_use_b(iss_use_b),
    .lk_a_nodep(lk_a_nodep), .lk_a_rf_val(lk_a_rf_val), .lk_a_tag(lk_a_tag),
    .lk_a_rob_hit(lk_a_rob_hit), .lk_a_rob_val(lk_a_rob_val),
    .lk_b_nodep(lk_b_nodep), .lk_b_rf_val(lk_b_rf_val), .lk_b_tag(lk_b_tag),
    .lk_b_rob_hit(lk_b_rob_hit), .lk_b_rob_val(lk_b_rob_val),
    .alu_status(alu_status), .alu_idx(alu_idx), .alu_val(alu_val),
    .mem_status(mem_status), .mem_idx(mem_idx), .mem_val(mem_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_addr(req_addr), .req_data(req_data), .req_rob(req_rob), .free_cnt(free_cnt)
  );

  // ---------------- behavioural reference model ----------------
  typedef struct { bit used; bit rdy; int tag; logic [31:0] val; } mo_t;
  typedef struct { int rob; int op; logic [31:0] imm; mo_t a; mo_t b; bit res; bit fresh; } me_t;

  me_t         mq[$];
  int          m_free = 32;
  bit          m_rvld = 0;
  int          m_rtype = 0;
  logic [31:0] m_raddr = '0, m_rdata = '0;
  int          m_rrob = 0;

  function automatic mo_t m_res(mo_t o, bit fresh, bit nodep, logic [31:0] rfv, int tg,
                                bit hit, logic [31:0] rbv);
    mo_t r = o;
    bit av = (alu_status == 2'b10);
    bit mv = (mem_status == 2'b10);
    if (!o.used) return r;
    if (fresh) begin
      if (nodep) begin r.rdy = 1; r.val = rfv; end
      else if (hit) begin r.rdy = 1; r.val = rbv; end
      else if (av && int'(alu_idx) == tg) begin r.rdy = 1; r.val = alu_val; r.tag = tg; end
      else if (mv && int'(mem_idx) == tg) begin r.rdy = 1; r.val = mem_val; r.tag = tg; end
      else begin r.rdy = 0; r.tag = tg; end
    end else if (!o.rdy) begin
      if (av && int'(alu_idx) == o.tag) begin r.rdy = 1; r.val = alu_val; end
      else if (mv && int'(mem_idx) == o.tag) begin r.rdy = 1; r.val = mem_val; end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    bit  ex;
    me_t ne;
    ex = 0;
    if (!rst_n || flush) begin
      mq.delete();
      m_free = 32;
      m_rvld = 0;
      m_rtype = 0;
    end else begin
      if (mq.size() != 0)
        if (mq[0].res && (!mq[0].a.used || mq[0].a.rdy) && (!mq[0].b.used || mq[0].b.rdy)
            && (!m_rvld || req_ready)) ex = 1;
      if (ex) begin
        m_rvld  = 1;
        m_rtype = mq[0].op;
        m_raddr = mq[0].a.val + mq[0].imm;
        m_rdata = mq[0].b.val;
        m_rrob  = mq[0].rob;
      end else if (req_ready) begin
        m_rvld  = 0;
        m_rtype = 0;
      end
      foreach (mq[k]) begin
        mq[k].a = m_res(mq[k].a, mq[k].fresh, lk_a_nodep, lk_a_rf_val, int'(lk_a_tag), lk_a_rob_hit, lk_a_rob_val);
        mq[k].b = m_res(mq[k].b, mq[k].fresh, lk_b_nodep, lk_b_rf_val, int'(lk_b_tag), lk_b_rob_hit, lk_b_rob_val);
        if (mq[k].fresh) begin mq[k].fresh = 0; mq[k].res = 1; end
      end
      if (ex) void'(mq.pop_front());
      if (iss_valid && m_free != 0) begin
        ne.rob = int'(iss_rob); ne.op = int'(iss_op); ne.imm = iss_imm;
        ne.a = '{used: iss_use_a, rdy: 0, tag: 0, val: '0};
        ne.b = '{used: iss_use_b, rdy: 0, tag: 0, val: '0};
        ne.res = 0; ne.fresh = 1;
        mq.push_back(ne);
        m_free--;
      end
      if (ex) m_free++;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    chk(free_cnt == 6'(m_free), "R8 free count vs model", 64'(free_cnt), 64'(m_free));
    chk(iss_ready == (m_free != 0), "R2 issue ready vs model", 64'(iss_ready), 64'(m_free != 0));
    chk(req_valid == m_rvld, "R7 request valid vs model", 64'(req_valid), 64'(m_rvld));
    chk(req_type == 3'(m_rtype), "R4 request type vs model", 64'(req_type), 64'(m_rtype));
    if (m_rvld) begin
      chk(req_addr == m_raddr, "R4 R5 R6 request address vs model", 64'(req_addr), 64'(m_raddr));
      chk(req_data == m_rdata, "R4 R5 R6 store data vs model", 64'(req_data), 64'(m_rdata));
      chk(req_rob == 5'(m_rrob), "R3 request tag order vs model", 64'(req_rob), 64'(m_rrob));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) compare_model();
  endtask

  task automatic idle_inputs();
    iss_valid = 0; flush = 0;
    lk_a_nodep = 0; lk_a_rob_hit = 0; lk_a_tag = '0;
    lk_b_nodep = 0; lk_b_rob_hit = 0; lk_b_tag = '0;
    alu_status = '0; mem_status = '0;
  endtask

  task automatic issue(input int rob, input int op, input logic [31:0] imm, input bit ua, input bit ub);
    iss_valid = 1; iss_rob = 5'(rob); iss_op = 3'(op); iss_imm = imm;
    iss_use_a = ua; iss_use_b = ub;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired, run did not complete");
      finish_run();
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(free_cnt == 6'd32, "R1 free after reset", 64'(free_cnt), 64'd32);
    chk(iss_ready == 1'b1, "R1 ready after reset", 64'(iss_ready), 64'd1);
    chk(req_valid == 1'b0, "R1 no request after reset", 64'(req_valid), 64'd0);
    chk(req_type == 3'd0, "R1 idle type after reset", 64'(req_type), 64'd0);

    // S1: register-file and reorder-buffer sourcing (R5, R10, R4)
    issue(3, 2, 32'h10, 1, 1);
    tick();
    chk(free_cnt == 6'd31, "R8 accept takes a slot", 64'(free_cnt), 64'd31);
    iss_valid = 0;
    lk_a_nodep = 1; lk_a_rf_val = 32'h100;
    lk_b_nodep = 0; lk_b_rob_hit = 1; lk_b_rob_val = 32'hABCD;
    lk_a_rob_hit = 1; lk_a_rob_val = 32'hDEAD;
    tick();
    chk(req_valid == 1'b0, "R10 no request during resolve", 64'(req_valid), 64'd0);
    idle_inputs();
    tick();
    chk(req_valid == 1'b1, "R10 request two edges after accept", 64'(req_valid), 64'd1);
    chk(req_addr == 32'h110, "R5 register value wins over rob", 64'(req_addr), 64'h110);
    chk(req_data == 32'hABCD, "R5 rob value forwarded", 64'(req_data), 64'hABCD);
    chk(req_type == 3'd2 && req_rob == 5'd3, "R4 type and tag", 64'({req_type, req_rob}), 64'({3'd2, 5'd3}));
    tick();
    chk(req_type == 3'd0, "R4 type zero when idle", 64'(req_type), 64'd0);

    // S2: status filter and memory broadcast capture (R6)
    issue(9, 1, 32'h4, 1, 0);
    tick();
    iss_valid = 0; lk_a_tag = 5'd7;
    tick();
    idle_inputs();
    alu_status = 2'b01; alu_idx = 5'd7; alu_val = 32'h99;
    tick(); tick();
    chk(req_valid == 1'b0, "R6 status other than 10 ignored", 64'(req_valid), 64'd0);
    alu_status = '0;
    mem_status = 2'b10; mem_idx = 5'd7; mem_val = 32'h40;
    tick();
    mem_status = '0;
    tick();
    chk(req_valid && req_addr == 32'h44 && req_rob == 5'd9, "R6 memory broadcast captured",
        64'(req_addr), 64'h44);
    tick();

    // S4: strict order behind a waiting head (R3)
    issue(1, 3, 32'h0, 1, 0);
    tick();
    issue(2, 4, 32'h8, 0, 0);
    lk_a_tag = 5'd5;
    tick();
    idle_inputs();
    tick(); tick(); tick();
    chk(req_valid == 1'b0, "R3 ready younger waits behind head", 64'(req_valid), 64'd0);
    alu_status = 2'b10; alu_idx = 5'd5; alu_val = 32'h200;
    tick();
    alu_status = '0;
    tick();
    chk(req_valid && req_rob == 5'd1 && req_addr == 32'h200, "R3 older executes first", 64'(req_rob), 64'd1);
    tick();
    chk(req_valid && req_rob == 5'd2, "R3 younger follows", 64'(req_rob), 64'd2);
    tick();

    // S3: fill under back-pressure, then flush against an issue (R2, R7, R9, R1)
    req_ready = 0;
    for (int n = 0; n < 40; n++) begin
      issue(n % 32, 5, 32'(n), 0, 0);
      tick();
    end
    chk(free_cnt == 6'd0, "R2 queue full", 64'(free_cnt), 64'd0);
    chk(iss_ready == 1'b0, "R2 ready low when full", 64'(iss_ready), 64'd0);
    chk(req_valid && req_rob == 5'd0, "R7 stalled request held", 64'(req_rob), 64'd0);
    tick();
    chk(free_cnt == 6'd0, "R2 issue while full ignored", 64'(free_cnt), 64'd0);
    flush = 1;
    issue(17, 6, 32'h0, 0, 0);
    tick();
    chk(free_cnt == 6'd32, "R1 flush empties", 64'(free_cnt), 64'd32);
    chk(req_valid == 1'b0, "R1 flush drops request", 64'(req_valid), 64'd0);
    idle_inputs();
    req_ready = 1;
    tick(); tick(); tick();
    chk(req_valid == 1'b0 && free_cnt == 6'd32, "R9 issue on flush edge dropped", 64'(free_cnt), 64'd32);

    // S5: random traffic compared to the model every clock
    void'($urandom(32'h5eed));
    for (int c = 0; c < 6000; c++) begin
      iss_valid    = ($urandom % 2) == 0;
      iss_rob      = 5'($urandom);
      iss_op       = 3'(($urandom % 7) + 1);
      iss_imm      = $urandom;
      iss_use_a    = ($urandom % 4) != 0;
      iss_use_b    = ($urandom % 2) == 0;
      lk_a_nodep   = ($urandom % 2) == 0;
      lk_a_rf_val  = $urandom;
      lk_a_tag     = 5'($urandom % 8);
      lk_a_rob_hit = ($urandom % 4) == 0;
      lk_a_rob_val = $urandom;
      lk_b_nodep   = ($urandom % 2) == 0;
      lk_b_rf_val  = $urandom;
      lk_b_tag     = 5'($urandom % 8);
      lk_b_rob_hit = ($urandom % 4) == 0;
      lk_b_rob_val = $urandom;
      alu_status   = 2'($urandom);
      alu_idx      = 5'($urandom % 8);
      alu_val      = $urandom;
      mem_status   = 2'($urandom);
      mem_idx      = 5'($urandom % 8);
      mem_val      = $urandom;
      req_ready    = ($urandom % 4) != 0;
      flush        = ($urandom % 200) == 0;
      tick();
    end
    idle_inputs();
    req_ready = 1;
    tick();

    done = 1;
    finish_run();
  end
endmodule